// File: doc/BRIEF.md
# Masked Address Break Comparator

This block is a single breakpoint channel for a processor debug unit. Software programs a break address, a per-bit address mask and a bus-cycle condition word through a small register port. The block watches every bus access that the core presents and raises a one-cycle break pulse when the access meets every enabled condition. A mask bit set to 1 removes that address bit from the comparison, so one channel can cover an aligned region as well as a single address.

The condition word selects which bus the access must come from (L bus or I bus), whether it must be an instruction fetch or a data access, whether it must be a read or a write, and which operand size it must have. A zero bus-selection code switches the channel off. Every register resets to zero, so the channel stays silent until it is configured. Register writes affect only later accesses.

Top module: `brk_match_top`

## Requirements
- R1: After reset the address, mask and condition registers all read as 0, and `brk_hit` is 0.
- R2: `reg_sel` picks the register: 0 is the break address, 1 is the address mask, 2 is the condition word, and 3 reads as 0 and ignores writes. The address and mask registers read back the full 32-bit value written to them.
- R3: Condition bits 15:8, and `reg_rdata` bits 31:8 when the condition word is selected, always read as 0. Writes to those bits have no effect.
- R4: When the bus-select field (condition bits 7:6) is 00, no access produces a hit.
- R5: Bus-select 01 and 11 both match only L-bus accesses (`acc_ibus`=0). Bus-select 10 matches only I-bus accesses (`acc_ibus`=1).
- R6: Address bit n takes part in the comparison only when mask bit n is 0. Each such bit must equal break-address bit n.
- R7: The kind field (bits 5:4) works as follows: 01 requires an instruction fetch (`acc_fetch`=1), 10 requires a data access (`acc_fetch`=0), and 00 or 11 accept both.
- R8: The direction field (bits 3:2) works as follows: 01 requires a read (`acc_write`=0), 10 requires a write (`acc_write`=1), and 00 or 11 accept both.
- R9: The size field (bits 1:0) works as follows: 00 accepts any size, 01 requires byte, 10 word and 11 longword, where `acc_size` encodes byte=0, word=1, long=2. The size condition applies only to data accesses.
- R10: `brk_hit` is 1 for exactly the one cycle that follows a cycle in which `acc_valid` was high and all conditions held. An access with `acc_valid` low never produces a hit.
- R11: An access in the same cycle as a register write is compared against the register values that were in place before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select (0 address, 1 mask, 2 condition) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register |
| acc_valid | input | 1 | Bus access strobe |
| acc_addr | input | 32 | Access address |
| acc_ibus | input | 1 | 1 = I-bus access, 0 = L-bus access |
| acc_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_size | input | 2 | Operand size: 0 byte, 1 word, 2 long |
| brk_hit | output | 1 | Registered one-cycle break pulse |

## Verification
All stored state can be read back, so a corrupted register bit appears at `reg_rdata` as soon as that register is selected. The same fault appears at `brk_hit` one cycle after the first access whose outcome depends on that bit. A faulty comparator or qualifier shows up as a missing or extra pulse exactly one clock after the offending access. The reference model therefore compares `brk_hit` on every cycle and not only at the end of a test. Accesses with randomly flipped address bits run against many mask and condition settings, so each field decode gets exercised against its neighbours.

// File: rtl/brk_pkg.sv
package brk_pkg;

   typedef enum logic [1:0] {
      SEL_BASE = 2'd0,
      SEL_MASK = 2'd1,
      SEL_COND = 2'd2,
      SEL_NONE = 2'd3
   } reg_sel_e;

   typedef enum logic [1:0] {
      BUS_OFF   = 2'b00,
      BUS_LOCAL = 2'b01,
      BUS_INSTR = 2'b10,
      BUS_ALIAS = 2'b11
   } bus_sel_e;

   // Live part of the condition word; bit order matters (decoded by the qualifier)
   typedef struct packed {
      logic [1:0] bus;   // bits 7:6
      logic [1:0] kind;  // bits 5:4
      logic [1:0] dir;   // bits 3:2
      logic [1:0] size;  // bits 1:0
   } cond_t;

   localparam int COND_LIVE_W = $bits(cond_t);
   localparam int COND_REG_W  = 16;

endpackage

// File: rtl/brk_regs.sv
module brk_regs
   import brk_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        sel,
   input  logic [DATA_W-1:0] wdata,
   output logic [ADDR_W-1:0] base_o,
   output logic [ADDR_W-1:0] mask_o,
   output cond_t             cond_o,
   output logic [DATA_W-1:0] rdata
);

   localparam int PAD_W = DATA_W - COND_LIVE_W;

   if (ADDR_W > DATA_W) begin : g_bad_width
      $error("brk_regs: ADDR_W must not exceed DATA_W");
   end
   if (DATA_W < COND_REG_W) begin : g_bad_data
      $error("brk_regs: DATA_W must hold the condition word");
   end

   logic [ADDR_W-1:0] base_q, mask_q;
   cond_t             cond_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         mask_q <= '0;
         cond_q <= '0;
      end else if (wr_en) begin
         case (reg_sel_e'(sel))
            SEL_BASE: base_q <= wdata[ADDR_W-1:0];
            SEL_MASK: mask_q <= wdata[ADDR_W-1:0];
            SEL_COND: cond_q <= cond_t'(wdata[COND_LIVE_W-1:0]);
            default:  ;
         endcase
      end
   end

   always_comb begin
      case (reg_sel_e'(sel))
         SEL_BASE: rdata = DATA_W'(base_q);
         SEL_MASK: rdata = DATA_W'(mask_q);
         SEL_COND: rdata = {{PAD_W{1'b0}}, cond_q};
         default:  rdata = '0;
      endcase
   end

   assign base_o = base_q;
   assign mask_o = mask_q;
   assign cond_o = cond_q;

   // R3: reserved part of the condition word is never visible
   a_r3_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_sel_e'(sel) == SEL_COND) |-> (rdata[DATA_W-1:COND_LIVE_W] == '0));

   // R2: unused select never returns data
   a_r2_none_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_sel_e'(sel) == SEL_NONE) |-> (rdata == '0));

endmodule

// File: rtl/brk_addr_match.sv
module brk_addr_match #(
   parameter int ADDR_W = 32,
   parameter int STYLE  = 1   // 0: vector reduction, 1: per-bit slices
)(
   input  logic [ADDR_W-1:0] addr,
   input  logic [ADDR_W-1:0] base,
   input  logic [ADDR_W-1:0] mask,
   output logic              equal
);

   if (STYLE != 0 && STYLE != 1) begin : g_bad_style
      $error("brk_addr_match: STYLE must be 0 or 1");
   end

   if (STYLE == 0) begin : g_vec
      assign equal = ~|((addr ^ base) & ~mask);
   end else begin : g_bits
      logic [ADDR_W-1:0] bit_ok;
      for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
         assign bit_ok[i] = mask[i] | (addr[i] ~^ base[i]);
      end
      assign equal = &bit_ok;
   end

endmodule

// File: rtl/brk_cycle_qual.sv
module brk_cycle_qual
   import brk_pkg::*;
(
   input  cond_t      cond,
   input  logic       ibus,
   input  logic       fetch,
   input  logic       write,
   input  logic [1:0] size,
   output logic       ok
);

   logic bus_ok, kind_ok, dir_ok, size_ok;

   always_comb begin
      case (bus_sel_e'(cond.bus))
         BUS_LOCAL, BUS_ALIAS: bus_ok = ~ibus;
         BUS_INSTR:            bus_ok = ibus;
         default:              bus_ok = 1'b0;
      endcase

      case (cond.kind)
         2'b01:   kind_ok = fetch;
         2'b10:   kind_ok = ~fetch;
         default: kind_ok = 1'b1;
      endcase

      case (cond.dir)
         2'b01:   dir_ok = ~write;
         2'b10:   dir_ok = write;
         default: dir_ok = 1'b1;
      endcase

      if (cond.size == 2'b00 || fetch) size_ok = 1'b1;
      else                             size_ok = (size == cond.size - 2'd1);
   end

   assign ok = bus_ok & kind_ok & dir_ok & size_ok;

endmodule

// File: rtl/brk_match_top.sv
module brk_match_top
   import brk_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int DATA_W    = 32,
   parameter int CMP_STYLE = 1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [1:0]        reg_sel,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              acc_valid,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic              acc_ibus,
   input  logic              acc_fetch,
   input  logic              acc_write,
   input  logic [1:0]        acc_size,
   output logic              brk_hit
);

   logic [ADDR_W-1:0] base_w, mask_w;
   cond_t             cond_w;
   logic              addr_eq, cyc_ok, hit_q;

   brk_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .sel(reg_sel),
      .wdata(reg_wdata), .base_o(base_w), .mask_o(mask_w),
      .cond_o(cond_w), .rdata(reg_rdata)
   );

   brk_addr_match #(.ADDR_W(ADDR_W), .STYLE(CMP_STYLE)) u_addr (
      .addr(acc_addr), .base(base_w), .mask(mask_w), .equal(addr_eq)
   );

   brk_cycle_qual u_qual (
      .cond(cond_w), .ibus(acc_ibus), .fetch(acc_fetch),
      .write(acc_write), .size(acc_size), .ok(cyc_ok)
   );

   // Comparison uses the settings held before any same-cycle write (R11)
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hit_q <= 1'b0;
      else        hit_q <= acc_valid & addr_eq & cyc_ok;
   end

   assign brk_hit = hit_q;

   // R10: a pulse needs a valid access one cycle earlier
   a_r10_hit_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
      brk_hit |-> $past(acc_valid));

   // R10: a qualifying access always yields a pulse
   a_r10_hit_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && addr_eq && cyc_ok) |=> brk_hit);

   // R4: disabled channel stays silent
   a_r4_off_silent: assert property (@(posedge clk) disable iff (!rst_n)
      brk_hit |-> ($past(cond_w.bus) != BUS_OFF));

   // R5: pulse only from the selected bus
   a_r5_bus_select: assert property (@(posedge clk) disable iff (!rst_n)
      brk_hit |-> ($past(cond_w.bus) == BUS_INSTR ? $past(acc_ibus) : !$past(acc_ibus)));

   // R6: unmasked bits agreed with the stored address
   a_r6_addr_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
      brk_hit |-> ((($past(acc_addr) ^ $past(base_w)) & ~$past(mask_w)) == '0));

endmodule

// File: tb/sim_brk_match_top.sv
`timescale 1ns/1ps
module sim_brk_match_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [1:0]  reg_sel = 2'd0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        acc_valid = 1'b0;
   logic [31:0] acc_addr = '0;
   logic        acc_ibus = 1'b0, acc_fetch = 1'b0, acc_write = 1'b0;
   logic [1:0]  acc_size = 2'd0;
   logic        brk_hit;

   int n_chk = 0, n_err = 0;
   string cur_req = "R1";
   bit done = 0;

   always #4 clk = ~clk;   // 125 MHz

   brk_match_top u0 (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .acc_valid(acc_valid),
      .acc_addr(acc_addr), .acc_ibus(acc_ibus), .acc_fetch(acc_fetch),
      .acc_write(acc_write), .acc_size(acc_size), .brk_hit(brk_hit)
   );

   // ---------------- reference model ----------------
   logic [31:0] m_base, m_mask, m_cond;
   bit          exp_hit;

   function automatic bit ref_match(logic [31:0] a, bit ib, bit fe, bit wr, logic [1:0] sz);
      int bs = m_cond[7:6];
      int kd = m_cond[5:4];
      int dr = m_cond[3:2];
      int sf = m_cond[1:0];
      if (bs == 0) return 0;
      if (bs == 2 && !ib) return 0;
      if (bs != 2 && ib) return 0;
      for (int i = 0; i < 32; i++)
         if (!m_mask[i] && a[i] != m_base[i]) return 0;
      if (kd == 1 && !fe) return 0;
      if (kd == 2 && fe) return 0;
      if (dr == 1 && wr) return 0;
      if (dr == 2 && !wr) return 0;
      if (sf != 0 && !fe && int'(sz) != sf - 1) return 0;
      return 1;
   endfunction

   function automatic logic [31:0] ref_read(logic [1:0] s);
      case (s)
         2'd0: return m_base;
         2'd1: return m_mask;
         2'd2: return m_cond;
         default: return 32'd0;
      endcase
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_base <= '0; m_mask <= '0; m_cond <= '0; exp_hit <= 0;
      end else begin
         exp_hit <= acc_valid && ref_match(acc_addr, acc_ibus, acc_fetch, acc_write, acc_size);
         if (reg_wr) begin
            case (reg_sel)
               2'd0: m_base <= reg_wdata;
               2'd1: m_mask <= reg_wdata;
               2'd2: m_cond <= reg_wdata & 32'h0000_00FF;
               default: ;
            endcase
         end
      end
   end

   // cycle-by-cycle comparison of the pulse (R10 timing, current feature tag)
   always @(negedge clk) begin
      if (rst_n && !done) begin
         n_chk++;
         if (brk_hit !== exp_hit) begin
            n_err++;
            $display("FAIL %s/R10: brk_hit=%0b expected %0b at %0t", cur_req, brk_hit, exp_hit, $time);
         end
      end
   end

   // ---------------- helpers ----------------
   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic step(bit wr, logic [1:0] s, logic [31:0] d, bit v,
                       logic [31:0] a, bit ib, bit fe, bit w, logic [1:0] sz);
      @(posedge clk); #2;
      reg_wr = wr; reg_sel = s; reg_wdata = d;
      acc_valid = v; acc_addr = a; acc_ibus = ib; acc_fetch = fe;
      acc_write = w; acc_size = sz;
   endtask

   task automatic idle();
      step(0, 2'd3, 32'd0, 0, 32'd0, 0, 0, 0, 2'd0);
   endtask

   task automatic wr_reg(logic [1:0] s, logic [31:0] d);
      step(1, s, d, 0, 32'd0, 0, 0, 0, 2'd0);
   endtask

   task automatic read_chk(string req, logic [1:0] s);
      step(0, s, 32'd0, 0, 32'd0, 0, 0, 0, 2'd0);
      @(negedge clk);
      check(req, reg_rdata, ref_read(s));
   endtask

   task automatic cfg(logic [31:0] b, logic [31:0] m, logic [15:0] c);
      wr_reg(2'd0, b); wr_reg(2'd1, m); wr_reg(2'd2, {16'd0, c});
      idle();
   endtask

   task automatic burst(string req, int n);
      cur_req = req;
      for (int i = 0; i < n; i++) begin
         logic [31:0] a;
         a = ($urandom_range(0, 1) == 0) ? (m_base ^ ($urandom & $urandom & $urandom)) : $urandom;
         step(0, 2'd3, 32'd0, ($urandom_range(0, 7) != 0), a,
              $urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1),
              2'($urandom_range(0, 2)));
      end
      idle();
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (150000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   // ---------------- stimulus ----------------
   initial begin
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      @(negedge clk);
      check("R1 hit", {31'd0, brk_hit}, 32'd0);
      for (int s = 0; s < 3; s++) read_chk("R1 reset value", 2'(s));

      // R2 readback
      wr_reg(2'd0, 32'hDEAD_BEEF); read_chk("R2 address", 2'd0);
      wr_reg(2'd1, 32'h0F0F_00FF); read_chk("R2 mask", 2'd1);
      wr_reg(2'd3, 32'hFFFF_FFFF); read_chk("R2 select 3", 2'd3);
      read_chk("R2 address kept", 2'd0);
      read_chk("R2 mask kept", 2'd1);

      // R3 reserved bits
      wr_reg(2'd2, 32'hFFFF_FF00); read_chk("R3 reserved", 2'd2);
      wr_reg(2'd2, 32'h0000_ABC4); read_chk("R3 reserved mixed", 2'd2);

      // R4 disabled
      cfg(32'h1234_5678, 32'hFFFF_FFFF, 16'h003F); burst("R4", 300);

      // R5 bus select codes
      cfg(32'h8000_0040, 32'h0000_000F, 16'h0040); burst("R5", 300);
      cfg(32'h8000_0040, 32'h0000_000F, 16'h0080); burst("R5", 300);
      cfg(32'h8000_0040, 32'h0000_000F, 16'h00C0); burst("R5", 300);

      // R6 masking
      cfg(32'hA5A5_5A5A, 32'h0000_0000, 16'h0040); burst("R6", 300);
      cfg(32'hA5A5_5A5A, 32'hFFFF_0000, 16'h0080); burst("R6", 300);
      cfg(32'h0000_0000, 32'hFFFF_FFFF, 16'h0040); burst("R6", 300);

      // R7 kind, R8 direction, R9 size
      for (int k = 0; k < 4; k++) begin
         cfg(32'h0000_1000, 32'h0000_00FF, 16'(8'h40 | (k << 4))); burst("R7", 200);
      end
      for (int d = 0; d < 4; d++) begin
         cfg(32'h0000_2000, 32'h0000_00FF, 16'(8'h80 | (d << 2))); burst("R8", 200);
      end
      for (int z = 0; z < 4; z++) begin
         cfg(32'h0000_3000, 32'h0000_00FF, 16'(8'hE0 | z)); burst("R9", 200);
         cfg(32'h0000_3000, 32'h0000_00FF, 16'(8'h50 | z)); burst("R9", 200);
      end

      // R10 valid low never hits
      cur_req = "R10";
      cfg(32'h0000_4000, 32'h0000_0000, 16'h0040);
      step(0, 2'd3, 32'd0, 0, 32'h0000_4000, 0, 0, 0, 2'd0);
      @(negedge clk); @(negedge clk);
      check("R10 invalid access", {31'd0, brk_hit}, 32'd0);
      step(0, 2'd3, 32'd0, 1, 32'h0000_4000, 0, 0, 0, 2'd0);
      idle();
      @(negedge clk);
      check("R10 pulse", {31'd0, brk_hit}, 32'd1);
      @(negedge clk);
      check("R10 single cycle", {31'd0, brk_hit}, 32'd0);

      // R11 same-cycle write uses old settings
      cur_req = "R11";
      step(1, 2'd2, 32'd0, 1, 32'h0000_4000, 0, 0, 0, 2'd0);
      idle();
      @(negedge clk);
      check("R11 old settings hit", {31'd0, brk_hit}, 32'd1);
      step(0, 2'd3, 32'd0, 1, 32'h0000_4000, 0, 0, 0, 2'd0);
      idle();
      @(negedge clk);
      check("R11 new settings apply", {31'd0, brk_hit}, 32'd0);
      step(1, 2'd2, 32'h40, 1, 32'h0000_4000, 0, 0, 0, 2'd0);
      idle();
      @(negedge clk);
      check("R11 enable not early", {31'd0, brk_hit}, 32'd0);
      burst("R11", 200);

      repeat (2) @(posedge clk);
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule